// File: doc/BRIEF.md
# Bus Error Capture Register

This block keeps a running record of the system-bus cycles seen by one node. On every bus cycle it loads the cycle's command, address and control fields into a capture register. When an error is reported, the capture register stops loading, so the failing cycle stays available for software to inspect later. Software reads the captured fields and a status word through a small CSR port. It clears the error flags by writing ones to them. Capture resumes once every primary error flag is zero again.

Errors that arrive while the record is frozen do not overwrite it. They set a matching lost-error flag instead. Lost flags never stop capture on their own. Two extra error inputs report parity faults in the tag control and tag store logic. These are folded onto the two not-acknowledged flags. Detecting the errors is done elsewhere; this block only receives one pulse per error.

Top module: `bus_err_capture`

## Requirements
- R1: While no primary flag is set, every cycle with `cyc_valid` high loads `cyc_cmd`, `cyc_addr` and `cyc_ctl` into the capture register on that clock edge.
- R2: While any primary flag is set, the captured fields do not change. They stay frozen until software has cleared every primary flag.
- R3: Lost flags do not freeze capture. With only lost flags set, bus cycles are still captured.
- R4: Reads return the data one cycle after `csr_rd`. Select 1 returns the captured address, zero-extended. Select 2 returns the command in bits [3:0] and the control byte in bits [11:4]. If capture is enabled and `cyc_valid` is high in the cycle of the read, the read returns that same cycle's fields.
- R5: `tag_ctl_perr` sets primary flag 0 (command/address not acknowledged). `tag_store_perr` sets primary flag 1 (write data not acknowledged).
- R6: An error pulse that arrives while a primary flag is set sets the lost flag at the same index (status bit 4+i). It leaves the primary flags and the captured fields unchanged.
- R7: Select 0 is the status word. Bits [3:0] are the primary flags, in the order command/address not acknowledged, write data not acknowledged, command/address parity, data parity. Bits [7:4] are the lost flags in the same order. Writing a 1 to a status bit clears that bit. If an error sets a bit in the same cycle that software clears it, the bit ends up set.
- R8: In the cycle where an error is first reported, that cycle's bus fields are the ones kept.
- R9: Reset sets every flag, the captured fields and `csr_rdata` to 0, and leaves capture enabled.
- R10: Writes to select 1 or 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | A bus cycle is present this clock |
| cyc_cmd | input | CMD_W | Command of the current bus cycle |
| cyc_addr | input | ADDR_W | Address of the current bus cycle |
| cyc_ctl | input | CTL_W | Control bits of the current bus cycle |
| err_det | input | 4 | One pulse per primary error kind (index = status bit) |
| tag_ctl_perr | input | 1 | Tag control parity fault |
| tag_store_perr | input | 1 | Tag store parity fault |
| csr_rd | input | 1 | Read request |
| csr_wr | input | 1 | Write request |
| csr_sel | input | 2 | Word select: 0 status, 1 address, 2 command/control |
| csr_wdata | input | DATA_W | Write data |
| csr_rdata | output | DATA_W | Registered read data |

## Verification
A software clear and a new error can land in the same cycle. The bench provokes this by raising an error pulse in the same cycle as a status write. Two cases are tested: clearing a lost bit while the same error recurs, and clearing a primary bit while a different error arrives. In each case the status word read back must show the set winning. The bench also checks a read that is itself a bus cycle. That read must return the very fields it carries, not the previously stored ones.

// File: rtl/bus_err_capture_pkg.sv
package bus_err_capture_pkg;
  localparam int unsigned NUM_ERR     = 4;
  localparam int unsigned F_CA_NACK   = 0;
  localparam int unsigned F_WD_NACK   = 1;
  localparam int unsigned F_CA_PAR    = 2;
  localparam int unsigned F_DATA_PAR  = 3;
  localparam int unsigned SEL_W       = 2;
  localparam logic [1:0]  SEL_STATUS  = 2'd0;
  localparam logic [1:0]  SEL_ADDR    = 2'd1;
  localparam logic [1:0]  SEL_CMDCTL  = 2'd2;
endpackage

// File: rtl/bec_flag_unit.sv
module bec_flag_unit
  import bus_err_capture_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_ERR-1:0] err_eff,
  input  logic               clr_en,
  input  logic [NUM_ERR-1:0] clr_prim,
  input  logic [NUM_ERR-1:0] clr_lost,
  output logic [NUM_ERR-1:0] prim_q,
  output logic [NUM_ERR-1:0] lost_q,
  output logic               frozen
);
  logic [NUM_ERR-1:0] set_prim, set_lost, clr_p, clr_l;

  assign frozen   = |prim_q;
  assign set_prim = frozen ? '0 : err_eff;
  assign set_lost = frozen ? err_eff : '0;
  assign clr_p    = clr_en ? clr_prim : '0;
  assign clr_l    = clr_en ? clr_lost : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      prim_q <= '0;
      lost_q <= '0;
    end else begin
      prim_q <= (prim_q & ~clr_p) | set_prim;
      lost_q <= (lost_q & ~clr_l) | set_lost;
    end
  end

  genvar i;
  generate
    for (i = 0; i < NUM_ERR; i++) begin : g_chk
      // R6: error while frozen lands in the lost flag
      p_lost_set_r6: assert property (@(posedge clk) disable iff (rst)
        (frozen && err_eff[i]) |=> lost_q[i]);
      // R7: a set in the same cycle as a clear wins
      p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (!frozen && err_eff[i] && clr_p[i]) |=> prim_q[i]);
      p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (clr_l[i] && !(frozen && err_eff[i])) |=> !lost_q[i]);
    end
  endgenerate
endmodule

// File: rtl/bec_snap_store.sv
module bec_snap_store #(
  parameter int unsigned W = 44
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  // R1: a load takes the presented snapshot
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(d));
endmodule

// File: rtl/bec_read_mux.sv
module bec_read_mux
  import bus_err_capture_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned CTL_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [SEL_W-1:0]   sel,
  input  logic               fwd,
  input  logic [ADDR_W-1:0]  live_addr,
  input  logic [CMD_W-1:0]   live_cmd,
  input  logic [CTL_W-1:0]   live_ctl,
  input  logic [ADDR_W-1:0]  st_addr,
  input  logic [CMD_W-1:0]   st_cmd,
  input  logic [CTL_W-1:0]   st_ctl,
  input  logic [NUM_ERR-1:0] prim,
  input  logic [NUM_ERR-1:0] lost,
  output logic [DATA_W-1:0]  rdata
);
  logic [ADDR_W-1:0] a_sel;
  logic [CMD_W-1:0]  c_sel;
  logic [CTL_W-1:0]  t_sel;
  logic [DATA_W-1:0] word;

  assign a_sel = fwd ? live_addr : st_addr;
  assign c_sel = fwd ? live_cmd  : st_cmd;
  assign t_sel = fwd ? live_ctl  : st_ctl;

  always_comb begin
    word = '0;
    unique case (sel)
      SEL_STATUS: word[2*NUM_ERR-1:0] = {lost, prim};
      SEL_ADDR:   word[ADDR_W-1:0]    = a_sel;
      SEL_CMDCTL: word[CMD_W+CTL_W-1:0] = {t_sel, c_sel};
      default:    word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= word;
  end

  // R4: a read that is itself a captured bus cycle returns its own address
  p_fwd_r4: assert property (@(posedge clk) disable iff (rst)
    (rd && fwd && sel == SEL_ADDR) |=> rdata[ADDR_W-1:0] == $past(live_addr));
endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
  import bus_err_capture_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CMD_W  = 4,
  parameter int unsigned CTL_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cyc_valid,
  input  logic [CMD_W-1:0]   cyc_cmd,
  input  logic [ADDR_W-1:0]  cyc_addr,
  input  logic [CTL_W-1:0]   cyc_ctl,
  input  logic [NUM_ERR-1:0] err_det,
  input  logic               tag_ctl_perr,
  input  logic               tag_store_perr,
  input  logic               csr_rd,
  input  logic               csr_wr,
  input  logic [SEL_W-1:0]   csr_sel,
  input  logic [DATA_W-1:0]  csr_wdata,
  output logic [DATA_W-1:0]  csr_rdata
);
  localparam int unsigned SNAP_W = ADDR_W + CMD_W + CTL_W;

  logic [NUM_ERR-1:0] err_eff, prim_q, lost_q;
  logic               frozen, cap_load, clr_en;
  logic [SNAP_W-1:0]  snap_d, snap_q;
  logic [ADDR_W-1:0]  st_addr;
  logic [CMD_W-1:0]   st_cmd;
  logic [CTL_W-1:0]   st_ctl;
  logic               unused_wdata;

  always_comb begin
    err_eff = err_det;
    err_eff[F_CA_NACK] = err_det[F_CA_NACK] | tag_ctl_perr;
    err_eff[F_WD_NACK] = err_det[F_WD_NACK] | tag_store_perr;
  end

  assign clr_en       = csr_wr && (csr_sel == SEL_STATUS);
  assign unused_wdata = ^csr_wdata[DATA_W-1:2*NUM_ERR];

  bec_flag_unit u_flags (
    .clk      (clk),
    .rst      (rst),
    .err_eff  (err_eff),
    .clr_en   (clr_en),
    .clr_prim (csr_wdata[NUM_ERR-1:0]),
    .clr_lost (csr_wdata[2*NUM_ERR-1:NUM_ERR]),
    .prim_q   (prim_q),
    .lost_q   (lost_q),
    .frozen   (frozen)
  );

  assign cap_load = cyc_valid && !frozen;
  assign snap_d   = {cyc_ctl, cyc_cmd, cyc_addr};

  bec_snap_store #(.W(SNAP_W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .load (cap_load),
    .d    (snap_d),
    .q    (snap_q)
  );

  assign st_addr = snap_q[ADDR_W-1:0];
  assign st_cmd  = snap_q[ADDR_W+CMD_W-1:ADDR_W];
  assign st_ctl  = snap_q[SNAP_W-1:ADDR_W+CMD_W];

  bec_read_mux #(
    .ADDR_W(ADDR_W), .CMD_W(CMD_W), .CTL_W(CTL_W), .DATA_W(DATA_W)
  ) u_rmux (
    .clk       (clk),
    .rst       (rst),
    .rd        (csr_rd),
    .sel       (csr_sel),
    .fwd       (cap_load),
    .live_addr (cyc_addr),
    .live_cmd  (cyc_cmd),
    .live_ctl  (cyc_ctl),
    .st_addr   (st_addr),
    .st_cmd    (st_cmd),
    .st_ctl    (st_ctl),
    .prim      (prim_q),
    .lost      (lost_q),
    .rdata     (csr_rdata)
  );

  // R2: frozen record does not move
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (|prim_q) |=> $stable(snap_q));
  // R3: lost flags alone do not stop capture
  p_lost_nonblock_r3: assert property (@(posedge clk) disable iff (rst)
    (prim_q == '0 && lost_q != '0 && cyc_valid) |=> st_addr == $past(cyc_addr));
  // R5: tag parity faults reach the not-acknowledged flags
  p_tag_map_r5: assert property (@(posedge clk) disable iff (rst)
    (prim_q == '0 && tag_ctl_perr) |=> prim_q[F_CA_NACK]);
  p_tag_store_r5: assert property (@(posedge clk) disable iff (rst)
    (prim_q == '0 && tag_store_perr) |=> prim_q[F_WD_NACK]);
  // R8: the first erroring cycle is the one kept
  p_first_err_r8: assert property (@(posedge clk) disable iff (rst)
    (prim_q == '0 && err_eff != '0 && cyc_valid) |=> st_addr == $past(cyc_addr));
endmodule

// File: tb/bus_err_capture_bench.sv
`timescale 1ns/100ps
module bus_err_capture_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_valid = 1'b0;
  logic [3:0]  cyc_cmd = '0;
  logic [31:0] cyc_addr = '0;
  logic [7:0]  cyc_ctl = '0;
  logic [3:0]  err_det = '0;
  logic        tag_ctl_perr = 1'b0, tag_store_perr = 1'b0;
  logic        csr_rd = 1'b0, csr_wr = 1'b0;
  logic [1:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bus_err_capture u_bus_err_capture (
    .clk(clk), .rst(rst), .cyc_valid(cyc_valid), .cyc_cmd(cyc_cmd),
    .cyc_addr(cyc_addr), .cyc_ctl(cyc_ctl), .err_det(err_det),
    .tag_ctl_perr(tag_ctl_perr), .tag_store_perr(tag_store_perr),
    .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  // advance one edge, then return all inputs to idle
  task automatic step();
    @(negedge clk);
    cyc_valid = 0; err_det = '0; tag_ctl_perr = 0; tag_store_perr = 0;
    csr_rd = 0; csr_wr = 0; csr_sel = '0; csr_wdata = '0;
  endtask

  task automatic bus(input logic [31:0] a, input logic [3:0] c, input logic [7:0] t,
                     input logic [3:0] e);
    cyc_valid = 1; cyc_addr = a; cyc_cmd = c; cyc_ctl = t; err_det = e;
    step();
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    csr_rd = 1; csr_sel = s;
    step();
    v = csr_rdata;
  endtask

  task automatic clear_all();
    csr_wr = 1; csr_sel = 2'd0; csr_wdata = 32'hFF;
    step();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R9 rdata after reset", csr_rdata, 0);
    rd(0, v); chk("R9 status after reset", v, 0);
    rd(1, v); chk("R9 addr after reset", v, 0);
  endtask

  task automatic t_capture();
    logic [31:0] v;
    bus(32'h1000_0010, 4'h3, 8'h11, 0);
    bus(32'h2000_0020, 4'h5, 8'h22, 0);
    rd(1, v); chk("R1 latest addr", v, 32'h2000_0020);
    rd(2, v); chk("R1 latest cmd/ctl", v, 32'h225);
  endtask

  task automatic t_self_read();
    logic [31:0] v;
    cyc_valid = 1; cyc_addr = 32'hCAFE_0000; cyc_cmd = 4'h7; cyc_ctl = 8'h3C;
    csr_rd = 1; csr_sel = 1;
    step(); v = csr_rdata;
    chk("R4 read returns its own cycle", v, 32'hCAFE_0000);
  endtask

  task automatic t_freeze_lost();
    logic [31:0] v;
    clear_all();
    bus(32'hE000_0E00, 4'hA, 8'h5C, 4'b0100);
    bus(32'hF000_0F00, 4'h1, 8'h01, 0);
    rd(1, v); chk("R8 first error addr kept", v, 32'hE000_0E00);
    rd(2, v); chk("R2 cmd/ctl frozen", v, 32'h5CA);
    rd(0, v); chk("R7 status after parity error", v, 32'h04);
    bus(32'h9999_0000, 4'h2, 8'h02, 4'b1000);
    rd(0, v); chk("R6 lost flag set", v, 32'h84);
    rd(1, v); chk("R6 record unchanged", v, 32'hE000_0E00);
    csr_wr = 1; csr_sel = 0; csr_wdata = 32'h04; step();
    rd(0, v); chk("R7 primary cleared, lost kept", v, 32'h80);
    bus(32'h4444_4444, 4'h4, 8'h44, 0);
    rd(1, v); chk("R3 capture with lost flag only", v, 32'h4444_4444);
  endtask

  task automatic t_tag();
    logic [31:0] v;
    clear_all();
    tag_ctl_perr = 1; step();
    rd(0, v); chk("R5 tag control parity", v, 32'h01);
    clear_all();
    tag_store_perr = 1; step();
    rd(0, v); chk("R5 tag store parity", v, 32'h02);
    clear_all();
    rd(0, v); chk("R7 clear all", v, 32'h00);
  endtask

  task automatic t_same_cycle();
    logic [31:0] v;
    clear_all();
    err_det = 4'b0001; step();
    err_det = 4'b0001; csr_wr = 1; csr_sel = 0; csr_wdata = 32'h10; step();
    rd(0, v); chk("R7 lost set beats clear", v, 32'h11);
    err_det = 4'b0100; csr_wr = 1; csr_sel = 0; csr_wdata = 32'h01; step();
    rd(0, v); chk("R7 clear primary with error to lost", v, 32'h50);
  endtask

  task automatic t_ro_words();
    logic [31:0] v;
    clear_all();
    bus(32'h0000_ABCD, 4'h6, 8'h66, 0);
    csr_wr = 1; csr_sel = 1; csr_wdata = 32'hFFFF_FFFF; step();
    csr_wr = 1; csr_sel = 2; csr_wdata = 32'hFFFF_FFFF; step();
    rd(1, v); chk("R10 addr write ignored", v, 32'h0000_ABCD);
    rd(2, v); chk("R10 cmd/ctl write ignored", v, 32'h666);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_capture();
    t_self_read();
    t_freeze_lost();
    t_tag();
    t_same_cycle();
    t_ro_words();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule